// File: doc/BRIEF.md
# Phase-Quantized Cubic Line Resampler

This block resamples one video line of 8-bit pixels to a new length. Output pixel `j` sits at position `j * step` on the input grid. `step` is an unsigned 16.16 fixed-point value, normally the input length divided by the output length. The fractional part of that position is snapped to one of `PHASES` evenly spaced phases. The phase index picks a row of four cubic-convolution weights, which use kernel parameter -0.5. Each weight holds `FRAC_BITS` fractional bits and is fixed when the block is built. The result is the weighted sum of the four input pixels around the position, rounded and clamped back to 8 bits.

Pixels arrive on a valid/ready stream and results leave on a valid/ready stream. The line lengths and the step are set on configuration inputs, which must hold steady for the whole line. A four-entry tap window slides over the input. It replicates the first and last pixels wherever the kernel reaches past either end of the line. When the output register is stalled, every piece of state freezes. After a line has produced all its outputs, the block swallows any input pixels the line has not yet used. It then starts the next line at position zero.

Top module: `cubic_scaler`

## Requirements
- R1: After reset `oValid` is low, and with `cfgInLen` ≥ 1 `iReady` is high before any pixel is sent.
- R2: Output `j` of a line is computed at position `p = j*cfgStep` (16.16). Let `k = floor(p)`, after the phase wrap of R3. The output is the weighted sum of input pixels `k-1, k, k+1, k+2`, with weights from the phase row. Outputs leave in order `j = 0, 1, 2, …`.
- R3: The phase index is `floor((frac*PHASES + 2^15) / 2^16)`, where `frac` is the low 16 bits of `p`. If that index equals `PHASES`, the block uses phase 0 and `k+1`.
- R4: Let `s = q/PHASES` for phase `q`. The weights are `(-s³+2s²-s)/2`, `(3s³-5s²+2)/2`, `(-3s³+4s²+s)/2` and `(s³-s²)/2`. Each is scaled by `2^FRAC_BITS` and rounded half away from zero. The shortfall from `2^FRAC_BITS` is added to the largest weight, taking the first in tap order on a tie, so that every row sums to exactly `2^FRAC_BITS`.
- R5: A tap index below 0 reads input pixel 0. A tap index at or beyond `cfgInLen` reads pixel `cfgInLen-1`.
- R6: The sum has `2^(FRAC_BITS-1)` added and is then shifted right arithmetically by `FRAC_BITS`. The result is clamped to 0…255.
- R7: With `cfgStep = 0x10000` and equal lengths, every output equals the input pixel at the same index.
- R8: While `oValid` is high and `oReady` is low, `oValid` stays high and `oData` stays unchanged. No output is lost or repeated.
- R9: A line takes exactly `cfgInLen` input pixels and gives exactly `cfgOutLen` outputs. Unused trailing inputs are absorbed. The next line restarts at position 0 with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStep | input | 32 | Position increment per output, 16.16 unsigned |
| cfgInLen | input | 16 | Input pixels per line (≥ 1) |
| cfgOutLen | input | 16 | Output pixels per line |
| iValid | input | 1 | Input pixel valid |
| iReady | output | 1 | Block accepts the input pixel |
| iData | input | 8 | Input pixel |
| oValid | output | 1 | Output pixel valid |
| oReady | input | 1 | Downstream accepts the output pixel |
| oData | output | 8 | Interpolated output pixel |

## Verification
Two things can happen in the same cycle: the downstream takes a finished pixel, and the next interpolation result loads into the output register. A 2x upscale produces two outputs from one window, so running it with `oReady` held high makes these handoffs fall back to back. Running the same line again with `oReady` dropped every third cycle checks the held data on each stalled cycle. In both runs the received sequence is compared in order against a model computed from the kernel formulas. A downscaled line, followed straight away by a flat line, shows that leftover inputs are drained at the same time as the final output leaves and that the next line starts clean.

// File: rtl/cubic_scaler_pkg.sv
package cubic_scaler_pkg;

  localparam int PHASE_IDX_W = 5;

  typedef struct packed {
    logic                   loadFirst;  // first pixel of a line fills the window
    logic                   shiftIn;    // shift a new input pixel in
    logic                   shiftRep;   // shift a replica of the last pixel in
    logic                   emit;       // compute and register an output
    logic [PHASE_IDX_W-1:0] phase;      // quantized phase index
  } tapCtrl_t;

  function automatic int roundDiv(input int num, input int den);
    if (num >= 0) return (num + den / 2) / den;
    return -((-num + den / 2) / den);
  endfunction

  // Quantized cubic-convolution weight, kernel parameter -0.5, row sum exactly 2^n
  function automatic int kernelCoef(input int m, input int n, input int p, input int tap);
    int w [4];
    int num [4];
    int den, sum, big;
    den    = 2 * m * m * m;
    num[0] = -p*p*p + 2*p*p*m - p*m*m;
    num[1] = 3*p*p*p - 5*p*p*m + 2*m*m*m;
    num[2] = -3*p*p*p + 4*p*p*m + p*m*m;
    num[3] = p*p*p - p*p*m;
    sum = 0;
    big = 0;
    for (int i = 0; i < 4; i++) begin
      w[i] = roundDiv(num[i] * (1 << n), den);
      sum += w[i];
      if (w[i] > w[big]) big = i;
    end
    w[big] += (1 << n) - sum;
    return w[tap];
  endfunction

endpackage

// File: rtl/cubic_scaler_ctrl.sv
module cubic_scaler_ctrl
  import cubic_scaler_pkg::*;
#(
  parameter int PHASES   = 16,
  parameter int LEN_W    = 16,
  parameter int POS_FRAC = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LEN_W+POS_FRAC-1:0] cfgStep,
  input  logic [LEN_W-1:0]          cfgInLen,
  input  logic [LEN_W-1:0]          cfgOutLen,
  input  logic                      iValid,
  output logic                      iReady,
  input  logic                      oValid,
  input  logic                      oReady,
  output tapCtrl_t                  str
);

  localparam int ACC_W = LEN_W + POS_FRAC;
  localparam int QW    = $clog2(PHASES) + 1;
  localparam int PW    = $clog2(PHASES);
  localparam int H_W   = LEN_W + 1;
  localparam int SC_W  = POS_FRAC + QW;

  logic [ACC_W-1:0] accQ;
  logic [H_W-1:0]   hCnt;
  logic [LEN_W-1:0] inCnt, outCnt;

  logic [SC_W-1:0] scaled;
  logic [QW-1:0]   qRaw;
  logic            wrapPh;
  logic [PW-1:0]   phIdx;
  logic [H_W-1:0]  kEff, need;
  logic outsLeft, inLeft, stall, wantShift, accept, lineDone;

  always_comb begin
    scaled = {{QW{1'b0}}, accQ[POS_FRAC-1:0]} * SC_W'(PHASES) + SC_W'(1 << (POS_FRAC - 1));
    qRaw   = scaled[SC_W-1:POS_FRAC];
    wrapPh = (qRaw == QW'(PHASES));
    phIdx  = wrapPh ? '0 : qRaw[PW-1:0];
    kEff   = {1'b0, accQ[ACC_W-1:POS_FRAC]} + H_W'(wrapPh);
    need   = kEff + H_W'(3);
  end

  always_comb begin
    outsLeft  = (outCnt != cfgOutLen);
    inLeft    = (inCnt != cfgInLen);
    stall     = oValid && !oReady;
    lineDone  = !outsLeft && !inLeft && !stall;
    wantShift = outsLeft && (hCnt < need);
    iReady    = !stall && inLeft && (wantShift || !outsLeft);
    accept    = iValid && iReady;
    str.loadFirst = accept && wantShift && (hCnt == '0);
    str.shiftIn   = accept && wantShift && (hCnt != '0);
    str.shiftRep  = !stall && wantShift && !inLeft && (hCnt != '0);
    str.emit      = !stall && outsLeft && (hCnt == need);
    str.phase     = PHASE_IDX_W'(phIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN || lineDone) begin
      accQ   <= '0;
      hCnt   <= '0;
      inCnt  <= '0;
      outCnt <= '0;
    end else begin
      if (accept) inCnt <= inCnt + 1'b1;
      if (str.loadFirst || str.shiftIn || str.shiftRep) hCnt <= hCnt + 1'b1;
      if (str.emit) begin
        accQ   <= accQ + cfgStep;
        outCnt <= outCnt + 1'b1;
      end
    end
  end

  // R8: a stalled output freezes position and window
  a_r8_stall_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (oValid && !oReady) |=> ($stable(accQ) && $stable(hCnt)));

  // R2: the window never runs ahead of the taps the current output needs
  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    hCnt <= need);

  // R9: per-line counts never pass the configured lengths
  a_r9_in_count: assert property (@(posedge clk) disable iff (!rstN)
    inCnt <= cfgInLen);
  a_r9_out_count: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= cfgOutLen);

endmodule

// File: rtl/cubic_scaler_dp.sv
module cubic_scaler_dp
  import cubic_scaler_pkg::*;
#(
  parameter int PHASES    = 16,
  parameter int FRAC_BITS = 6,
  parameter int PIX_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tapCtrl_t         str,
  input  logic [PIX_W-1:0] iData,
  input  logic             oReady,
  output logic             oValid,
  output logic [PIX_W-1:0] oData
);

  localparam int CW    = FRAC_BITS + 2;
  localparam int SUM_W = PIX_W + CW + 3;
  localparam int PW    = $clog2(PHASES);
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);
  localparam logic signed [SUM_W-1:0] HALF    = SUM_W'(1 << (FRAC_BITS - 1));

  logic signed [CW-1:0] coefTab [PHASES][4];

  for (genvar p = 0; p < PHASES; p++) begin : g_ph
    for (genvar t = 0; t < 4; t++) begin : g_tap
      assign coefTab[p][t] = CW'(kernelCoef(PHASES, FRAC_BITS, p, t));
    end
  end

  logic [PIX_W-1:0] win [4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) win[i] <= '0;
    end else if (str.loadFirst) begin
      for (int i = 0; i < 4; i++) win[i] <= iData;
    end else if (str.shiftIn || str.shiftRep) begin
      for (int i = 0; i < 3; i++) win[i] <= win[i+1];
      if (str.shiftIn) win[3] <= iData;
    end
  end

  logic [PW-1:0]          ph;
  logic signed [SUM_W-1:0] acc, rounded, shifted;
  logic [PIX_W-1:0]       pixOut;

  always_comb begin
    ph  = str.phase[PW-1:0];
    acc = '0;
    for (int i = 0; i < 4; i++)
      acc += $signed({{(SUM_W-PIX_W){1'b0}}, win[i]}) * SUM_W'(coefTab[ph][i]);
    rounded = acc + HALF;
    shifted = rounded >>> FRAC_BITS;
    if (shifted < 0)            pixOut = '0;
    else if (shifted > PIX_MAX) pixOut = '1;
    else                        pixOut = shifted[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oValid <= 1'b0;
      oData  <= '0;
    end else if (str.emit) begin
      oValid <= 1'b1;
      oData  <= pixOut;
    end else if (oReady) begin
      oValid <= 1'b0;
    end
  end

  // R8: held output stays valid and unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (oValid && !oReady) |=> (oValid && $stable(oData)));

  // R2: every emit strobe appears as a valid output next cycle
  a_r2_emit_loads: assert property (@(posedge clk) disable iff (!rstN)
    str.emit |=> oValid);

endmodule

// File: rtl/cubic_scaler.sv
module cubic_scaler
  import cubic_scaler_pkg::*;
#(
  parameter int PHASES    = 16,
  parameter int FRAC_BITS = 6,
  parameter int PIX_W     = 8,
  parameter int LEN_W     = 16,
  parameter int POS_FRAC  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LEN_W+POS_FRAC-1:0] cfgStep,
  input  logic [LEN_W-1:0]          cfgInLen,
  input  logic [LEN_W-1:0]          cfgOutLen,
  input  logic                      iValid,
  output logic                      iReady,
  input  logic [PIX_W-1:0]          iData,
  output logic                      oValid,
  input  logic                      oReady,
  output logic [PIX_W-1:0]          oData
);

  tapCtrl_t str;

  cubic_scaler_ctrl #(.PHASES(PHASES), .LEN_W(LEN_W), .POS_FRAC(POS_FRAC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgStep(cfgStep), .cfgInLen(cfgInLen),
    .cfgOutLen(cfgOutLen), .iValid(iValid), .iReady(iReady),
    .oValid(oValid), .oReady(oReady), .str(str)
  );

  cubic_scaler_dp #(.PHASES(PHASES), .FRAC_BITS(FRAC_BITS), .PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .iData(iData),
    .oReady(oReady), .oValid(oValid), .oData(oData)
  );

endmodule

// File: tb/sim_cubic_scaler.sv
module sim_cubic_scaler;

  localparam int M = 16;
  localparam int N = 6;

  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] cfgStep = 32'h10000;
  logic [15:0] cfgInLen = 16'd8, cfgOutLen = 16'd8;
  logic        iValid = 0, oReady = 1;
  logic [7:0]  iData = 0;
  logic        iReady, oValid;
  logic [7:0]  oData;

  cubic_scaler u0 (.*);

  always #4 clk = ~clk;  // 125 MHz

  int errs = 0, checks = 0, cyc = 0;
  int cT [M][4];
  logic [7:0] px [64];
  int got [128];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input longint num, input longint den);
    if (num < 0) return -int'(((-num) * 2 + den) / (2 * den));
    return int'((num * 2 + den) / (2 * den));
  endfunction

  // R4 table built from the kernel polynomials
  task automatic buildTab();
    int c3 [4] = '{-1, 3, -3, 1};
    int c2 [4] = '{2, -5, 4, -1};
    int c1 [4] = '{-1, 0, 1, 0};
    int c0 [4] = '{0, 2, 0, 0};
    for (int p = 0; p < M; p++) begin
      longint den = 2 * longint'(M) * M * M;
      int s = 0, mx = 0;
      for (int t = 0; t < 4; t++) begin
        longint num = c3[t]*p*p*p + c2[t]*p*p*M + c1[t]*p*M*M + c0[t]*M*M*M;
        cT[p][t] = rnd(num * (1 << N), den);
        s += cT[p][t];
      end
      for (int t = 1; t < 4; t++) if (cT[p][t] > cT[p][mx]) mx = t;
      cT[p][mx] += (1 << N) - s;
    end
  endtask

  function automatic int expOut(input int j, input int step, input int inLen);
    longint pos = longint'(j) * step;
    int k = int'(pos >> 16);
    int fr = int'(pos & 64'hFFFF);
    int q = (fr * M + 32768) >> 16;
    int sum = 0, v;
    if (q == M) begin k++; q = 0; end
    for (int t = 0; t < 4; t++) begin
      int idx = k - 1 + t;
      if (idx < 0) idx = 0;
      if (idx > inLen - 1) idx = inLen - 1;
      sum += cT[q][t] * int'(px[idx]);
    end
    v = (sum + (1 << (N - 1))) >>> N;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic feed(input int inLen);
    for (int i = 0; i < inLen; i++) begin
      @(negedge clk);
      iValid = 1; iData = px[i];
      #1;
      while (!iReady) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    iValid = 0;
  endtask

  task automatic collect(input int outLen, input int mode, input int step,
                         input int inLen, input string tag);
    int j = 0;
    bit held = 0;
    logic [7:0] hd = 0;
    while (j < outLen) begin
      @(negedge clk);
      if (held) chk(oValid && oData == hd, "R8 held output", oData, hd);
      oReady = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      #1;
      held = oValid && !oReady;
      hd = oData;
      if (oValid && oReady) begin
        int e = expOut(j, step, inLen);
        got[j] = oData;
        chk(oData == e, tag, oData, e);
        j++;
      end
    end
    oReady = 1;
  endtask

  task automatic runLine(input int step, input int inLen, input int outLen,
                         input int mode, input string tag);
    @(negedge clk);
    cfgStep = step; cfgInLen = inLen; cfgOutLen = outLen;
    fork
      feed(inLen);
      collect(outLen, mode, step, inLen, tag);
    join
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!oValid, "R9 no extra output", oValid, 0);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(!oValid, "R1 oValid after reset", oValid, 0);
    chk(iReady, "R1 iReady after reset", iReady, 1);
  endtask

  task automatic testIdentity();
    for (int i = 0; i < 8; i++) px[i] = 8'(i * 37 + 5);
    runLine(32'h10000, 8, 8, 0, "R7 R2 identity");
    for (int i = 0; i < 8; i++) chk(got[i] == px[i], "R7 copy", got[i], px[i]);
  endtask

  task automatic testUpscale(input int mode);
    px[0] = 10; px[1] = 200; px[2] = 30; px[3] = 90; px[4] = 250; px[5] = 0;
    runLine(32'h8000, 6, 12, mode, mode ? "R8 R5 upscale stalled" : "R2 R5 upscale");
  endtask

  task automatic testClamp();
    for (int i = 0; i < 6; i++) px[i] = (i < 3) ? 8'd0 : 8'd255;
    runLine(32'h4000, 6, 24, 0, "R6 clamp");
    chk(got[7] == 0, "R6 undershoot clamp", got[7], 0);     // k=1 s=.75 -> negative
    chk(got[13] == 255, "R6 overshoot clamp", got[13], 255); // k=3 s=.25 -> above 255
  endtask

  task automatic testWrap();
    for (int i = 0; i < 16; i++) px[i] = 8'(i * 13 + 7);
    runLine(32'h1F800, 16, 8, 0, "R3 wrap");
    chk(got[1] == px[2], "R3 phase wrap to next pixel", got[1], px[2]);
  endtask

  task automatic testDownFlat();
    for (int i = 0; i < 12; i++) px[i] = 8'(250 - i * 19);
    runLine(32'h18000, 12, 6, 0, "R9 downscale drain");
    for (int i = 0; i < 4; i++) px[i] = 100;
    runLine(32'h1111, 4, 40, 1, "R4 R9 flat row sum");
    for (int i = 0; i < 40; i++)
      if (got[i] != 100) chk(0, "R4 flat line", got[i], 100);
    chk(got[0] == 100 && got[39] == 100, "R4 flat ends", got[39], 100);
  endtask

  initial begin
    buildTab();
    repeat (4) @(negedge clk);
    rstN = 1;
    testReset();
    testIdentity();
    testUpscale(0);
    testUpscale(1);
    testClamp();
    testWrap();
    testDownFlat();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule